// File: doc/BRIEF.md
# Delta Varint Address-Trace Encoder

This block compresses a stream of memory-access trace records. Each record carries a 32-bit address and a 64-bit timestamp. For every accepted record the encoder forms two differences against the previously accepted record. The first is the address difference, read as a signed 32-bit number and zigzag-mapped so that small negative steps stay short. The second is the timestamp difference, read as an unsigned 64-bit number. Both are emitted as variable-length byte codes on a byte-wide output stream, and the consumer can stall that stream.

The previous-address and previous-timestamp registers are cleared only by reset. They carry across the whole stream, so a consumer that drains output in batches sees deltas that continue unbroken from one batch to the next. A record is accepted only when the encoder is idle. Its bytes then leave one per output handshake, and the final byte of the record is flagged.

Top module: `trace_delta_encoder`

## Requirements
- R1: After reset, rec_ready is 1 and out_valid is 0, and both previous-value registers hold zero, so the first record is coded against address 0 and time 0.
- R2: The address field codes z = (d << 1) ^ (d >>> 31), where d = rec_addr − previous address taken as a signed 32-bit value. For example, d = −1 codes as the single byte 0x01.
- R3: The time field codes rec_time − previous time modulo 2^64, so a timestamp smaller than the previous one gives a large wrapped delta.
- R4: Each field is coded in groups of 7 bits, least significant group first, with the group in out_data[6:0]. out_data[7] is 1 on every byte of a field except that field's final byte.
- R5: All bytes of the address field leave before any byte of the time field of the same record.
- R6: out_last is 1 only on the final byte of the time field, and on that byte out_data[7] is 0.
- R7: A zero delta codes as the single byte 0x00, so a record identical to its predecessor produces exactly two bytes, both 0x00.
- R8: The address field never exceeds 5 bytes and the time field never exceeds 10 bytes. An address delta of 0x80000000 gives 5 bytes, and a time delta of all ones gives 10 bytes.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values into the next cycle.
- R10: rec_ready is 0 whenever out_valid is 1, so no record is accepted while bytes of the current one are pending. An accepted record presents its first byte in the following cycle.
- R11: The previous-value registers take the values of each accepted record, whatever the output stalls or gaps between records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Input record offered |
| rec_ready | output | 1 | Encoder can accept a record |
| rec_addr | input | 32 | Record address |
| rec_time | input | 64 | Record timestamp |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Coded byte |
| out_last | output | 1 | Final byte of the record |

## Verification
The encoder is driven with a first record against the reset state, then a repeated record (zero deltas), a one-step backward address, the most negative address delta and a wrapped all-ones time delta. Together these separate single-byte, multi-byte and maximum-length codes, and they expose any mistake in the zigzag sign handling or in the modular subtraction. A chain of records under a stalling consumer shows that the stored previous values and the held output bytes survive backpressure. A reference coder in the bench compares every byte, its position, the flags and the byte count.

// File: rtl/tde_pkg.sv
package tde_pkg;
    localparam int ADDR_W  = 32;
    localparam int TIME_W  = 64;
    localparam int BYTE_W  = 8;
    localparam int GROUP_W = BYTE_W - 1;
    localparam int MAX_ADDR_BYTES = (ADDR_W + GROUP_W - 1) / GROUP_W;
    localparam int MAX_TIME_BYTES = (TIME_W + GROUP_W - 1) / GROUP_W;
    localparam int MAX_REC_BYTES  = MAX_ADDR_BYTES + MAX_TIME_BYTES;
    localparam int CNT_W = $clog2(MAX_REC_BYTES + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_TIME = 2'd2
    } tde_state_e;

    typedef struct packed {
        tde_state_e          state;
        logic [ADDR_W-1:0]   prev_addr;
        logic [TIME_W-1:0]   prev_time;
        logic [TIME_W-1:0]   shift_val;
        logic [TIME_W-1:0]   time_hold;
    } tde_regs_t;
endpackage

// File: rtl/tde_delta.sv
module tde_delta #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    output logic [W-1:0] diff
);
    // modular difference; the reader decides on signedness
    always_comb begin
        diff = cur - prev;
    end
endmodule

// File: rtl/tde_zigzag.sv
module tde_zigzag #(
    parameter int W = 32
) (
    input  logic [W-1:0] delta,
    output logic [W-1:0] mapped
);
    // interleave signs: 0,-1,1,-2,2 -> 0,1,2,3,4
    always_comb begin
        mapped = {delta[W-2:0], 1'b0} ^ {W{delta[W-1]}};
    end
endmodule

// File: rtl/tde_varint_lane.sv
module tde_varint_lane #(
    parameter int W       = 64,
    parameter int GROUP_W = 7
) (
    input  logic [W-1:0]       val,
    output logic [GROUP_W:0]   code_byte,
    output logic               more,
    output logic [W-1:0]       rest
);
    always_comb begin
        rest      = val >> GROUP_W;
        more      = |rest;
        code_byte = {more, val[GROUP_W-1:0]};
    end
endmodule

// File: rtl/trace_delta_encoder.sv
module trace_delta_encoder
    import tde_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [31:0]       rec_addr,
    input  logic [63:0]       rec_time,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last
);
    tde_regs_t r_q, r_d;

    logic [ADDR_W-1:0] addr_diff;
    logic [ADDR_W-1:0] addr_zz;
    logic [TIME_W-1:0] time_diff;
    logic [BYTE_W-1:0] lane_byte;
    logic              lane_more;
    logic [TIME_W-1:0] lane_rest;

    tde_delta #(.W(ADDR_W)) u_addr_delta (
        .cur  (rec_addr),
        .prev (r_q.prev_addr),
        .diff (addr_diff)
    );

    tde_zigzag #(.W(ADDR_W)) u_zigzag (
        .delta  (addr_diff),
        .mapped (addr_zz)
    );

    tde_delta #(.W(TIME_W)) u_time_delta (
        .cur  (rec_time),
        .prev (r_q.prev_time),
        .diff (time_diff)
    );

    tde_varint_lane #(.W(TIME_W), .GROUP_W(GROUP_W)) u_lane (
        .val       (r_q.shift_val),
        .code_byte (lane_byte),
        .more      (lane_more),
        .rest      (lane_rest)
    );

    // next-state logic
    always_comb begin
        r_d       = r_q;
        rec_ready = (r_q.state == ST_IDLE);
        out_valid = (r_q.state != ST_IDLE);
        out_data  = lane_byte;
        out_last  = (r_q.state == ST_TIME) && !lane_more;

        unique case (r_q.state)
            ST_IDLE: begin
                if (rec_valid) begin
                    r_d.prev_addr = rec_addr;
                    r_d.prev_time = rec_time;
                    r_d.shift_val = {{(TIME_W-ADDR_W){1'b0}}, addr_zz};
                    r_d.time_hold = time_diff;
                    r_d.state     = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (out_ready) begin
                    if (lane_more) begin
                        r_d.shift_val = lane_rest;
                    end else begin
                        r_d.shift_val = r_q.time_hold;
                        r_d.state     = ST_TIME;
                    end
                end
            end
            ST_TIME: begin
                if (out_ready) begin
                    if (lane_more) begin
                        r_d.shift_val = lane_rest;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.prev_addr <= '0;
            r_q.prev_time <= '0;
            r_q.shift_val <= '0;
            r_q.time_hold <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/tde_checker.sv
module tde_checker
    import tde_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rec_valid,
    input logic       rec_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (out_valid && out_ready) begin
            cnt_q <= out_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R9: stalled byte holds
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R10: accepted record shows a byte next cycle, never accepted while busy
    a_r10_accept_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ready |=> out_valid && !rec_ready);

    // R6: record end flag only on a byte without continuation
    a_r6_last_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> !out_data[7]);

    // R5: the first byte of a record belongs to the address field
    a_r5_first_not_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !out_last);

    // R8: bounded record length
    a_r8_max_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cnt_q < CNT_W'(MAX_REC_BYTES)));
endmodule

bind trace_delta_encoder tde_checker u_tde_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/tb_trace_delta_encoder.sv
`timescale 1ns/1ps
module tb_trace_delta_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [31:0] rec_addr = '0;
    logic [63:0] rec_time = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0]  exp_q[$];
    logic [31:0] m_addr = '0;
    logic [63:0] m_time = '0;

    always #2.5 clk = ~clk;

    trace_delta_encoder dut (
        .clk (clk), .rst_n (rst_n),
        .rec_valid (rec_valid), .rec_ready (rec_ready),
        .rec_addr (rec_addr), .rec_time (rec_time),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_data (out_data), .out_last (out_last)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push_varint(input logic [63:0] v);
        logic [63:0] x = v;
        do begin
            exp_q.push_back({(x >> 7) != 64'd0, x[6:0]});
            x = x >> 7;
        end while (x != 64'd0);
    endtask

    // send one record, collect its bytes, compare against the reference coder
    task automatic run_rec(input string req, input logic [31:0] a, input logic [63:0] t,
                           input int stall, output int nbytes);
        logic [31:0] d;
        int idx = 0;
        int cyc = 0;
        bit done = 0;
        bit hs, rv, rl, rr, held = 0, bad_ready = 0, bad_hold = 0;
        logic [7:0] rd, hd = '0;
        logic hl = 1'b0;
        d = a - m_addr;
        exp_q.delete();
        push_varint({32'd0, (d << 1) ^ {32{d[31]}}});
        push_varint(t - m_time);
        m_addr = a;
        m_time = t;
        rec_addr = a;
        rec_time = t;
        rec_valid = 1'b1;
        forever begin
            hs = rec_ready;
            @(posedge clk); #1;
            if (hs) break;
        end
        rec_valid = 1'b0;
        while (!done && cyc < 100) begin
            out_ready = (stall == 0) || (cyc % 3 == 2);
            cyc++;
            rv = out_valid; rd = out_data; rl = out_last; rr = out_ready;
            if (rv && rec_ready) bad_ready = 1;
            if (held && (!rv || rd !== hd || rl !== hl)) bad_hold = 1;
            @(posedge clk); #1;
            if (rv && rr) begin
                if (idx < exp_q.size()) begin
                    check($sformatf("%s (R4 R5 byte %0d)", req, idx), {56'd0, rd}, {56'd0, exp_q[idx]});
                    check($sformatf("%s (R6 last flag byte %0d)", req, idx), {63'd0, rl},
                          {63'd0, idx == exp_q.size() - 1});
                end
                idx++;
                if (rl) done = 1;
            end
            held = rv && !rr; hd = rd; hl = rl;
        end
        out_ready = 1'b0;
        check({req, " byte count"}, idx, exp_q.size());
        check({req, " R10 no accept while busy"}, {63'd0, bad_ready}, 64'd0);
        check({req, " R9 hold under stall"}, {63'd0, bad_hold}, 64'd0);
        nbytes = idx;
    endtask

    task automatic t_reset;
        check("R1 rec_ready after reset", {63'd0, rec_ready}, 64'd1);
        check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_first;
        int n;
        run_rec("R1 first record vs zero state", 32'h0000_0010, 64'd5, 0, n);
        check("R1 first record length", n, 2);
    endtask

    task automatic t_zero;
        int n;
        run_rec("R7 zero deltas", 32'h0000_0010, 64'd5, 0, n);
        check("R7 two bytes for identical record", n, 2);
    endtask

    task automatic t_negative;
        int n;
        run_rec("R2 backward step", 32'h0000_000F, 64'd300, 0, n);
        check("R2 short code for -1 plus 2-byte time", n, 3);
    endtask

    task automatic t_extremes;
        int n;
        run_rec("R8 R3 wrapped all-ones time", 32'h0000_000F, 64'd299, 0, n);
        check("R8 one plus ten bytes", n, 11);
        run_rec("R8 most negative address delta", 32'h8000_000F, 64'd299, 0, n);
        check("R8 five plus one bytes", n, 6);
    endtask

    task automatic t_backpressure;
        int n;
        run_rec("R9 stalled long record", 32'h1234_5678, 64'hFEDC_BA98_7654_3210, 1, n);
    endtask

    task automatic t_chain;
        int n;
        for (int i = 0; i < 6; i++) begin
            run_rec($sformatf("R11 chained record %0d", i), m_addr + 32'(i * 4096) - 32'd64,
                    m_time + 64'(i * 77 + 1), i % 2, n);
            repeat (i) @(posedge clk);
            #0;
        end
    endtask

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_first();
        t_zero();
        t_negative();
        t_extremes();
        t_backpressure();
        t_chain();
        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule